// File: doc/BRIEF.md
# Split-Mode Programmable Delay Line

This block delays a byte stream by a programmable number of clock cycles. A 4-bit length code sets the depth. The count includes both the register that captures the input and the register that drives the output. In its default form the block has a code offset of three, so the delay runs from 3 cycles at code 0 up to 18 cycles at code 15.

A mode input splits the byte into two 4-bit lanes. While the mode is set, the upper lane is held at the deepest tap (18 cycles) and the lower lane still follows the code. With the mode clear, all eight bits share the coded depth. Typical uses are aligning one lane of a video or filter pipeline against the other, or matching the latency of a parallel path.

A build parameter selects a plain single-lane variant instead. In that variant all eight bits share one delay of code plus one cycles (1 to 16), and the mode input has no effect. The length code and the mode are registered before they are used, so a change takes effect one clock after it is captured. Storage is one shift chain with a separate tap selector for each lane.

Top module: `dly_line_split`

## Requirements
- R1: Data, length code and mode are sampled only on the rising clock edge, and `dout` comes from a register. A change of any input between edges leaves `dout` unchanged until the next rising edge.
- R2: With `split_mode` = 0 in the split build, all eight bits of a sample presented before edge N appear together on `dout` right after edge N + L − 1, where L = `len_code` + 3.
- R3: The length range ends are exact in the split build: code 4'b0000 gives a delay of 3 cycles and code 4'b1111 gives a delay of 18 cycles.
- R4: With `split_mode` = 1, `dout[7:4]` carries the upper nibble of the sample from 18 cycles earlier, whatever the code is and whenever the code changes.
- R5: With `split_mode` = 1, `dout[3:0]` carries the lower nibble delayed by `len_code` + 3 cycles.
- R6: `len_code` and `split_mode` pass through a register. A value sampled at edge M selects the tap used for the output word that is loaded at edge M + 1.
- R7: In the plain build (SPLIT = 0), all eight bits share a delay of `len_code` + 1 cycles. Code 0 gives 1 cycle, where the output register takes the raw input. The mode input is ignored.
- R8: A rising edge with `rst` = 1 clears every chain stage, the output register and the registered controls to zero. Samples that were in flight before the reset never reach `dout`.
- R9: When the code changes, the output reads from the new tap on the first word that uses it. Samples may repeat or be skipped, and no flush is inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W (8) | Data word entering the line |
| len_code | input | CODE_W (4) | Length code, registered before use |
| split_mode | input | 1 | 1 = pin the upper lane to the deepest tap (split build only) |
| dout | output | DATA_W (8) | Delayed data word from the output register |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the defaults (8-bit data, 4-bit code, split lanes), which cover depths 3 to 18 and the pinned upper lane. The other uses SPLIT = 0, which reaches the 1-cycle case where the output register samples the raw input, and the 16-cycle deep end. Both copies are driven through steady codes, a code that changes every cycle, mode toggling and a reset in the middle of the run. This shows tap switching, control latency and reset flushing against a queue-style reference.

// File: rtl/dly_line_pkg.sv
package dly_line_pkg;

    // Role of one lane's tap selector
    typedef enum logic {
        LANE_TRACK  = 1'b0,   // follows the registered length code
        LANE_PINNED = 1'b1    // jumps to the deepest tap while split mode is set
    } lane_role_e;

    // Code-to-length offset (length = code + offset)
    function automatic int len_offset(input bit split);
        return split ? 3 : 1;
    endfunction

    // Number of taps: tap k delivers a total delay of k+1 once the output register is counted
    function automatic int tap_count(input int code_w, input bit split);
        return (1 << code_w) + len_offset(split) - 1;
    endfunction

endpackage

// File: rtl/dly_ctrl.sv
module dly_ctrl #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic              split_i,
    output logic [CODE_W-1:0] code_o,
    output logic              split_o,
    output logic              armed_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              split;
        logic              armed;   // 1 once an edge without reset has passed
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.code  = code_i;
        ctrl_d.split = split_i;
        ctrl_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign code_o  = ctrl_q.code;
    assign split_o = ctrl_q.split;
    assign armed_o = ctrl_q.armed;

endmodule

// File: rtl/dly_chain.sv
module dly_chain #(
    parameter int DATA_W = 8,
    parameter int NSTG   = 17
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DATA_W-1:0]           din_i,
    output logic [NSTG:0][DATA_W-1:0]   taps_o
);

    typedef struct packed {
        logic [NSTG-1:0][DATA_W-1:0] stg;   // stg[0] is the input register
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d        = chain_q;
        chain_d.stg[0] = din_i;
        for (int k = 1; k < NSTG; k++) begin
            chain_d.stg[k] = chain_q.stg[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    // Tap 0 is the raw input word; tap k+1 is stage k
    always_comb begin
        taps_o[0] = din_i;
        for (int k = 0; k < NSTG; k++) begin
            taps_o[k+1] = chain_q.stg[k];
        end
    end

endmodule

// File: rtl/dly_lane.sv
module dly_lane #(
    parameter int                      LANE_W = 4,
    parameter int                      CODE_W = 4,
    parameter int                      NTAP   = 18,
    parameter int                      TAP_W  = 5,
    parameter int                      OFFSET = 3,
    parameter dly_line_pkg::lane_role_e ROLE  = dly_line_pkg::LANE_TRACK
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NTAP-1:0][LANE_W-1:0]   taps_i,
    input  logic [CODE_W-1:0]             code_i,
    input  logic                          split_i,
    output logic [TAP_W-1:0]              sel_o,
    output logic [LANE_W-1:0]             dout_o
);
    import dly_line_pkg::*;

    localparam logic [TAP_W-1:0] DEEPEST = TAP_W'(NTAP - 1);
    localparam logic [TAP_W-1:0] BIAS    = TAP_W'(OFFSET - 1);

    typedef struct packed {
        logic [LANE_W-1:0] dout;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        if (ROLE == LANE_PINNED && split_i) sel_o = DEEPEST;
        else                                sel_o = TAP_W'(code_i) + BIAS;
    end

    always_comb begin
        lane_d      = lane_q;
        lane_d.dout = taps_i[sel_o];
    end

    always_ff @(posedge clk) begin
        if (rst) lane_q <= '0;
        else     lane_q <= lane_d;
    end

    assign dout_o = lane_q.dout;

endmodule

// File: rtl/dly_line_split.sv
module dly_line_split #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 4,
    parameter bit SPLIT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] len_code,
    input  logic              split_mode,
    output logic [DATA_W-1:0] dout
);
    import dly_line_pkg::*;

    localparam int LANES  = SPLIT ? 2 : 1;
    localparam int LANE_W = DATA_W / LANES;
    localparam int OFFSET = len_offset(SPLIT);
    localparam int NTAP   = tap_count(CODE_W, SPLIT);
    localparam int NSTG   = NTAP - 1;
    localparam int TAP_W  = $clog2(NTAP);

    logic [CODE_W-1:0]            code_q;
    logic                         split_q;
    logic                         armed_q;
    logic [NTAP-1:0][DATA_W-1:0]  taps;
    logic [LANES-1:0][TAP_W-1:0]  lane_sel;

    dly_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .code_i  (len_code),
        .split_i (split_mode),
        .code_o  (code_q),
        .split_o (split_q),
        .armed_o (armed_q)
    );

    dly_chain #(.DATA_W(DATA_W), .NSTG(NSTG)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .din_i  (din),
        .taps_o (taps)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam lane_role_e ROLE_L = (SPLIT && l == LANES - 1) ? LANE_PINNED : LANE_TRACK;
        logic [NTAP-1:0][LANE_W-1:0] lane_taps;

        always_comb begin
            for (int k = 0; k < NTAP; k++) begin
                lane_taps[k] = taps[k][l*LANE_W +: LANE_W];
            end
        end

        dly_lane #(
            .LANE_W (LANE_W),
            .CODE_W (CODE_W),
            .NTAP   (NTAP),
            .TAP_W  (TAP_W),
            .OFFSET (OFFSET),
            .ROLE   (ROLE_L)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .taps_i  (lane_taps),
            .code_i  (code_q),
            .split_i (split_q),
            .sel_o   (lane_sel[l]),
            .dout_o  (dout[l*LANE_W +: LANE_W])
        );
    end

    // R6
    ctrl_latency_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $stable(len_code) && $stable(split_mode)
        |=> $stable(lane_sel[0]) && $stable(lane_sel[LANES-1]));

    if (SPLIT) begin : g_split_chk
        // R2
        lanes_agree_chk: assert property (@(posedge clk) disable iff (rst)
            !split_q |-> lane_sel[0] == lane_sel[LANES-1]);

        // R4
        pinned_tap_chk: assert property (@(posedge clk) disable iff (rst)
            armed_q && split_q && $past(split_q) |-> $stable(lane_sel[LANES-1]));

        // R8
        flush_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
            !armed_q |=> dout == '0);
    end

endmodule

// File: tb/dly_line_split_tb.sv
module dly_line_split_tb;

    localparam int PER   = 4;
    localparam int HDEPTH = 2048;

    logic clk = 1'b0;
    always #(PER/2) clk = ~clk;

    logic       rst;
    logic [7:0] din;
    logic [3:0] code;
    logic       mode;
    logic [7:0] dout_s, dout_p;

    dly_line_split u_dut (
        .clk(clk), .rst(rst), .din(din), .len_code(code),
        .split_mode(mode), .dout(dout_s)
    );

    dly_line_split #(.SPLIT(1'b0)) u_plain (
        .clk(clk), .rst(rst), .din(din), .len_code(code),
        .split_mode(mode), .dout(dout_p)
    );

    int n_chk = 0;
    int n_fail = 0;
    int e = -1;
    bit done = 1'b0;

    logic [7:0] d_h [HDEPTH];
    logic [3:0] c_h [HDEPTH];
    logic       m_h [HDEPTH];
    logic       r_h [HDEPTH];

    // Value that left the input at edge i, as seen at edge cur (0 if a reset came between)
    function automatic logic [7:0] src(input int i, input int cur);
        if (i < 0) return 8'h00;
        for (int k = i; k <= cur; k++) if (r_h[k]) return 8'h00;
        return d_h[i];
    endfunction

    function automatic logic [3:0] ctl_code(input int cur);
        if (cur < 1 || r_h[cur-1]) return 4'd0;
        return c_h[cur-1];
    endfunction

    function automatic logic ctl_mode(input int cur);
        if (cur < 1 || r_h[cur-1]) return 1'b0;
        return m_h[cur-1];
    endfunction

    function automatic logic [7:0] exp_split(input int cur);
        int lo_l, hi_l;
        logic [7:0] lo, hi;
        if (r_h[cur]) return 8'h00;
        lo_l = int'(ctl_code(cur)) + 3;
        hi_l = ctl_mode(cur) ? 18 : lo_l;
        lo = src(cur - lo_l + 1, cur);
        hi = src(cur - hi_l + 1, cur);
        return {hi[7:4], lo[3:0]};
    endfunction

    function automatic logic [7:0] exp_plain(input int cur);
        int len;
        if (r_h[cur]) return 8'h00;
        len = int'(ctl_code(cur)) + 1;
        return src(cur - len + 1, cur);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: edge %0d dout=%h expected %h", tag, e, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [7:0] d, input logic [3:0] c,
                        input logic m, input string tag_s, input string tag_p);
        logic [7:0] hold_s, hold_p;
        hold_s = dout_s;
        hold_p = dout_p;
        rst = r; din = d; code = c; mode = m;
        #1;
        if (e >= 0) begin
            // R1: new inputs between edges do not move the output
            check("R1", dout_s, hold_s);
            check("R1", dout_p, hold_p);
        end
        @(posedge clk);
        e++;
        r_h[e] = r;
        d_h[e] = r ? 8'h00 : d;
        c_h[e] = c;
        m_h[e] = m;
        #1;
        check(tag_s, dout_s, exp_split(e));
        check(tag_p, dout_p, exp_plain(e));
    endtask

    task automatic run(input int n, input logic [3:0] c, input logic m, input string tag_s);
        for (int i = 0; i < n; i++) step(1'b0, 8'($urandom), c, m, tag_s, "R7");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst = 1'b1; din = 8'h00; code = 4'd0; mode = 1'b0;
        // R8: reset with busy inputs gives zero
        for (int i = 0; i < 3; i++) step(1'b1, 8'hA5, 4'd7, 1'b1, "R8", "R8");
        run(40, 4'd0,  1'b0, "R3");           // shortest split length 3, plain length 1
        run(40, 4'd15, 1'b0, "R3");           // longest split length 18, plain 16
        run(40, 4'd5,  1'b0, "R2");
        run(40, 4'd0,  1'b1, "R5");           // split mode, low lane at 3
        run(30, 4'd9,  1'b1, "R5");
        for (int b = 0; b < 12; b++) run(5, 4'(b * 7), 1'b1, "R4");
        for (int b = 0; b < 20; b++) run(3, 4'(b * 5 + 2), 1'(b % 3 == 0), "R6");
        for (int i = 0; i < 200; i++) step(1'b0, 8'($urandom), 4'($urandom), 1'($urandom), "R9", "R9");
        // R8: mid-run reset discards samples in flight
        run(10, 4'd15, 1'b1, "R4");
        for (int i = 0; i < 2; i++) step(1'b1, 8'h3C, 4'd15, 1'b1, "R8", "R8");
        run(25, 4'd15, 1'b1, "R8");
        run(25, 4'd2,  1'b0, "R2");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(PER * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, edge %0d expected completion", e);
            summary();
            $finish;
        end
    end

endmodule